// File: doc/BRIEF.md
# Management Serial Bus Command Master

This block drives a clause-22 management serial bus (clock MDC, bidirectional data MDIO) from one 32-bit command word. Software writes a word that holds an operation code, a 5-bit PHY address, a 5-bit register address and 16 bits of write data. If the start bit is also set, the block sends the complete frame on the bus. While the frame is running, the start bit reads back as 1 and acts as a busy flag.

When the frame ends, the block clears the busy flag. After a read, the same word also returns the 16 data bits that came back from the PHY. A fail flag in the word reports that no PHY pulled the line low during the turnaround. MDC is divided down from the system clock by a parameter and is held low between transactions. Data leaving the block changes on falling MDC edges. Data entering the block is sampled on rising MDC edges. A write to the word while busy is set has no effect.

Top module: `mdio_cmd_master`

## Requirements
- R1: After reset, the command word reads 0, `mdc` is 0, `mdio_oe` is 0 and `mdio_o` is 1.
- R2: A write accepted while idle loads bit 29 (start) and bits 27:0 of the written word. It clears bit 28 (fail). Bits 31:30 always read 0. If bit 29 is 0, the word is only stored and no frame starts.
- R3: While bit 29 reads 1, every write is ignored. This includes a write in the same cycle in which the transaction completes.
- R4: `mdc` is 0 whenever the block is idle. During a transaction its period is 2*DIV system clocks, and its first rising edge comes DIV clocks after the launching write.
- R5: The frame has 64 bits, sent MSB first within each field: 32 ones, then 0,1, then the opcode (bits 27:26), the PHY address (bits 25:21), the register address (bits 20:16), a 2-bit turnaround, and the 16 data bits. The first bit appears in the launch cycle. Each following bit appears when `mdc` falls.
- R6: Any opcode other than 2'b10 (2'b01 is write) keeps `mdio_oe` high for all 64 bits and drives the turnaround as 1,0. Bits 15:0 are not changed, and the fail flag stays 0.
- R7: For opcode 2'b10 (read), `mdio_oe` goes low at the first turnaround bit and stays low until the end of the frame. When idle, `mdio_oe` is 0.
- R8: Busy (bit 29) clears on the rising `mdc` edge of the last bit, exactly 127*DIV clocks after the launching write. At that point `mdc` returns low.
- R9: On completion of a read, bits 15:0 hold the 16 bits sampled on the rising edges of the data bits, first sampled bit in bit 15.
- R10: On completion of a read, bit 28 is set if `mdio_i` was high at the rising edge of the second turnaround bit, and cleared otherwise. It can rise at no other time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_we | input | 1 | Write strobe for the command word |
| cmd_wdata | input | 32 | Value to write into the command word |
| cmd_rdata | output | 32 | Current command word: busy, fail, fields, data |
| mdc | output | 1 | Management bus clock |
| mdio_o | output | 1 | Management data, output value |
| mdio_oe | output | 1 | Management data, output enable |
| mdio_i | input | 1 | Management data, input value |

## Verification
Two events can land on the same clock edge: a software write to the command word, and the completion of a frame, which clears busy and stores the read result. To provoke this, the bench watches its own model's transaction counter and raises the write strobe in the cycle just before completion. The bench then checks that the word holds the read result and fail flag rather than the written value. It also checks that a repeat of the same write one cycle later is accepted.

// File: rtl/mdio_cmd_pkg.sv
package mdio_cmd_pkg;
  localparam int CMD_W      = 32;
  localparam int START_POS  = 29;
  localparam int FAIL_POS   = 28;
  localparam logic [1:0] OP_READ  = 2'b10;
  localparam logic [1:0] OP_WRITE = 2'b01;
  localparam int IDX_W      = 7;
  localparam logic [IDX_W-1:0] PRE_LAST   = 7'd31;
  localparam logic [IDX_W-1:0] TA_FIRST   = 7'd46;
  localparam logic [IDX_W-1:0] TA_SECOND  = 7'd47;
  localparam logic [IDX_W-1:0] DATA_FIRST = 7'd48;
  localparam logic [IDX_W-1:0] LAST_IDX   = 7'd63;

  // Bit of the 64-bit frame at position idx (0 = first on the wire)
  function automatic logic frame_bit(input logic [IDX_W-1:0] idx,
                                     input logic [CMD_W-1:0] cmd);
    logic [31:0] tail;
    logic [IDX_W-1:0] rev;
    tail = {2'b01, cmd[27:16], 2'b10, cmd[15:0]};
    rev  = LAST_IDX - idx;
    if (idx <= PRE_LAST) return 1'b1;
    return tail[rev[4:0]];
  endfunction
endpackage

// File: rtl/mdio_mdc_div.sv
module mdio_mdc_div #(
  parameter int DIV = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic run,
  input  logic halt,
  output logic mdc,
  output logic rise,
  output logic fall
);
  localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [CW-1:0] WRAP_AT = CW'(DIV - 1);

  logic [CW-1:0] cnt;
  logic          wrap;

  assign wrap = (cnt == WRAP_AT);
  assign rise = run && wrap && !mdc;
  assign fall = run && wrap && mdc;

  always_ff @(posedge clk) begin
    if (rst || !run) begin
      cnt <= '0;
      mdc <= 1'b0;
    end else if (wrap) begin
      cnt <= '0;
      mdc <= halt ? 1'b0 : ~mdc;
    end else begin
      cnt <= cnt + 1'b1;
    end
  end
endmodule

// File: rtl/mdio_frame_eng.sv
module mdio_frame_eng
  import mdio_cmd_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             launch,
  input  logic [CMD_W-1:0] launch_cmd,
  input  logic [CMD_W-1:0] cmd,
  input  logic             rise,
  input  logic             fall,
  input  logic             mdio_i,
  output logic             last,
  output logic             mdio_o,
  output logic             mdio_oe,
  output logic             fail_seen,
  output logic [15:0]      rdata
);
  logic [IDX_W-1:0] idx;
  logic [IDX_W-1:0] idx_nx;
  logic [15:0]      shift;
  logic             is_rd;
  logic             done;

  assign is_rd  = (cmd[27:26] == OP_READ);
  assign last   = (idx == LAST_IDX);
  assign done   = rise && last;
  assign idx_nx = idx + 7'd1;
  assign rdata  = {shift[14:0], mdio_i};

  always_ff @(posedge clk) begin
    if (rst) begin
      idx       <= '0;
      mdio_o    <= 1'b1;
      mdio_oe   <= 1'b0;
      shift     <= '0;
      fail_seen <= 1'b0;
    end else if (launch) begin
      idx       <= '0;
      mdio_o    <= frame_bit('0, launch_cmd);
      mdio_oe   <= 1'b1;
      fail_seen <= 1'b0;
    end else if (done) begin
      mdio_o    <= 1'b1;
      mdio_oe   <= 1'b0;
    end else begin
      if (rise && is_rd) begin
        if (idx == TA_SECOND) fail_seen <= mdio_i;
        if (idx >= DATA_FIRST) shift <= {shift[14:0], mdio_i};
      end
      if (fall) begin
        idx     <= idx_nx;
        mdio_o  <= frame_bit(idx_nx, cmd);
        mdio_oe <= !(is_rd && idx_nx >= TA_FIRST);
      end
    end
  end
endmodule

// File: rtl/mdio_cmd_master.sv
module mdio_cmd_master
  import mdio_cmd_pkg::*;
#(
  parameter int DIV = 4
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        cmd_we,
  input  logic [31:0] cmd_wdata,
  output logic [31:0] cmd_rdata,
  output logic        mdc,
  output logic        mdio_o,
  output logic        mdio_oe,
  input  logic        mdio_i
);
  logic [CMD_W-1:0] cmd_q;
  logic             busy, accept, launch;
  logic             rise, fall, last, done;
  logic             fail_seen;
  logic [15:0]      rdata;

  assign busy   = cmd_q[START_POS];
  assign accept = cmd_we && !busy;
  assign launch = accept && cmd_wdata[START_POS];
  assign done   = rise && last;

  always_ff @(posedge clk) begin
    if (rst) begin
      cmd_q <= '0;
    end else if (accept) begin
      cmd_q <= {2'b00, cmd_wdata[START_POS], 1'b0, cmd_wdata[27:0]};
    end else if (done) begin
      cmd_q[START_POS] <= 1'b0;
      if (cmd_q[27:26] == OP_READ) begin
        cmd_q[FAIL_POS] <= fail_seen;
        cmd_q[15:0]     <= rdata;
      end
    end
  end

  mdio_mdc_div #(.DIV(DIV)) u_div (
    .clk  (clk),
    .rst  (rst),
    .run  (busy),
    .halt (last),
    .mdc  (mdc),
    .rise (rise),
    .fall (fall)
  );

  mdio_frame_eng u_eng (
    .clk        (clk),
    .rst        (rst),
    .launch     (launch),
    .launch_cmd (cmd_wdata),
    .cmd        (cmd_q),
    .rise       (rise),
    .fall       (fall),
    .mdio_i     (mdio_i),
    .last       (last),
    .mdio_o     (mdio_o),
    .mdio_oe    (mdio_oe),
    .fail_seen  (fail_seen),
    .rdata      (rdata)
  );

  assign cmd_rdata = cmd_q;
endmodule

// File: rtl/mdio_cmd_master_chk.sv
module mdio_cmd_master_chk (
  input logic        clk,
  input logic        rst,
  input logic        cmd_we,
  input logic [31:0] cmd_rdata,
  input logic        mdc,
  input logic        mdio_o,
  input logic        mdio_oe
);
  p_idle_mdc_low_r4: assert property (@(posedge clk) disable iff (rst)
    !cmd_rdata[29] |-> !mdc);

  p_idle_release_r7: assert property (@(posedge clk) disable iff (rst)
    !cmd_rdata[29] |-> !mdio_oe);

  p_busy_hdr_hold_r3: assert property (@(posedge clk) disable iff (rst)
    (cmd_rdata[29] && cmd_we) |=> (cmd_rdata[27:16] == $past(cmd_rdata[27:16])));

  p_top_bits_zero_r2: assert property (@(posedge clk) disable iff (rst)
    cmd_rdata[29] |-> (cmd_rdata[31:30] == 2'b00));

  p_change_on_fall_r5: assert property (@(posedge clk) disable iff (rst)
    (cmd_rdata[29] && $past(cmd_rdata[29]) && !$fell(mdc)) |-> $stable(mdio_o));

  p_fail_at_done_r10: assert property (@(posedge clk) disable iff (rst)
    $rose(cmd_rdata[28]) |-> $fell(cmd_rdata[29]));

  p_drive_all_r6: assert property (@(posedge clk) disable iff (rst)
    (cmd_rdata[29] && cmd_rdata[27:26] != 2'b10) |-> mdio_oe);
endmodule

bind mdio_cmd_master mdio_cmd_master_chk u_chk (
  .clk       (clk),
  .rst       (rst),
  .cmd_we    (cmd_we),
  .cmd_rdata (cmd_rdata),
  .mdc       (mdc),
  .mdio_o    (mdio_o),
  .mdio_oe   (mdio_oe)
);

// File: tb/mdio_cmd_master_test.sv
module mdio_cmd_master_test;
  localparam int CLK_PERIOD = 10;
  localparam int DIV        = 3;
  localparam int TXN        = 127 * DIV;
  localparam int WATCHDOG   = 50000;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cmd_we = 1'b0;
  logic [31:0] cmd_wdata = '0;
  logic [31:0] cmd_rdata;
  logic        mdc, mdio_o, mdio_oe;
  logic        mdio_i = 1'b1;

  int total = 0;
  int bad   = 0;
  int cyc   = 0;
  bit ended = 0;

  // reference model state
  logic [31:0] m_reg = '0;
  bit          m_busy = 0;
  int          m_k = 0;
  bit          phy_present = 1;
  logic [15:0] phy_data = 16'h0000;

  mdio_cmd_master #(.DIV(DIV)) uut (
    .clk(clk), .rst(rst), .cmd_we(cmd_we), .cmd_wdata(cmd_wdata),
    .cmd_rdata(cmd_rdata), .mdc(mdc), .mdio_o(mdio_o),
    .mdio_oe(mdio_oe), .mdio_i(mdio_i)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h t=%0t", tag, act, exp, $time);
    end
  endtask

  task automatic finish_run();
    if (!ended) begin
      ended = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  // model update on each clock
  always @(posedge clk) begin
    cyc++;
    if (rst) begin
      m_reg = '0; m_busy = 0; m_k = 0;
    end else if (m_busy) begin
      m_k++;
      if (m_k == TXN) begin
        m_busy = 0;
        m_reg[29] = 1'b0;
        if (m_reg[27:26] == 2'b10) begin
          m_reg[28]   = !phy_present;
          m_reg[15:0] = phy_present ? phy_data : 16'hFFFF;
        end
      end
    end else if (cmd_we) begin
      m_reg = {2'b00, cmd_wdata[29], 1'b0, cmd_wdata[27:0]};
      if (cmd_wdata[29]) begin m_busy = 1; m_k = 0; end
    end
    if (cyc > WATCHDOG) begin
      total++; bad++;
      $display("FAIL watchdog expired");
      finish_run();
    end
  end

  // PHY model and per-cycle comparison, away from the active edge
  always @(negedge clk) begin
    int b;
    logic [63:0] frame;
    logic e_mdc, e_oe, e_o;
    b = m_k / (2 * DIV);
    mdio_i = 1'b1;
    if (m_busy && m_reg[27:26] == 2'b10) begin
      if (b == 47) mdio_i = !phy_present;
      else if (b >= 48) mdio_i = phy_present ? phy_data[63 - b] : 1'b1;
    end
    if (!rst) begin
      frame = {32'hFFFF_FFFF, 2'b01, m_reg[27:16], 2'b10, m_reg[15:0]};
      e_mdc = m_busy ? (((m_k / DIV) % 2) == 1) : 1'b0;
      e_oe  = m_busy && !(m_reg[27:26] == 2'b10 && b >= 46);
      e_o   = m_busy ? frame[63 - b] : 1'b1;
      chk("R2 R3 R8 R9 R10 word", cmd_rdata, m_reg);
      chk("R4 mdc", {31'd0, mdc}, {31'd0, e_mdc});
      chk("R6 R7 oe", {31'd0, mdio_oe}, {31'd0, e_oe});
      if (e_oe || !m_busy) chk("R5 R6 data out", {31'd0, mdio_o}, {31'd0, e_o});
    end
  end

  task automatic write_cmd(input logic [31:0] d);
    @(negedge clk);
    cmd_we = 1'b1; cmd_wdata = d;
    @(negedge clk);
    cmd_we = 1'b0;
  endtask

  task automatic wait_idle();
    while (cmd_rdata[29]) @(negedge clk);
  endtask

  function automatic logic [31:0] mk(input logic st, input logic [1:0] op,
                                     input logic [4:0] pa, input logic [4:0] ra,
                                     input logic [15:0] d);
    return {2'b00, st, 1'b0, op, pa, ra, d};
  endfunction

  initial begin
    int c0, n;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1 reset state (sampled just before release takes effect)
    chk("R1 word", cmd_rdata, 32'h0);
    chk("R1 mdc", {31'd0, mdc}, 32'd0);
    chk("R1 oe", {31'd0, mdio_oe}, 32'd0);
    chk("R1 out", {31'd0, mdio_o}, 32'd1);

    // R2 store without start
    write_cmd(32'h0ABC_1234);
    chk("R2 store only", cmd_rdata, 32'h0ABC_1234);
    write_cmd(32'hD000_0005);
    chk("R2 top and fail bits dropped", cmd_rdata, 32'h0000_0005);

    // R6 write transaction, R4 first rise, R3 ignore while busy, R8 length
    write_cmd(mk(1, 2'b01, 5'h11, 5'h0A, 16'hA55A));
    c0 = cyc; n = 0;
    while (!mdc) begin @(negedge clk); n++; end
    chk("R4 first rise delay", n, DIV);
    write_cmd(32'h2FFF_FFFF);
    chk("R3 ignored mid-frame", cmd_rdata, mk(1, 2'b01, 5'h11, 5'h0A, 16'hA55A));
    wait_idle();
    chk("R8 duration", cyc - c0, TXN);
    chk("R6 write result", cmd_rdata, mk(0, 2'b01, 5'h11, 5'h0A, 16'hA55A));

    // R9 read with PHY answering
    phy_present = 1; phy_data = 16'h3C96;
    write_cmd(mk(1, 2'b10, 5'h03, 5'h02, 16'h0000));
    wait_idle();
    chk("R9 read data", {16'd0, cmd_rdata[15:0]}, 32'h3C96);
    chk("R10 no fail", {31'd0, cmd_rdata[28]}, 32'd0);

    // R10 read with no PHY
    phy_present = 0;
    write_cmd(mk(1, 2'b10, 5'h1F, 5'h1F, 16'h1234));
    wait_idle();
    chk("R10 fail set", {31'd0, cmd_rdata[28]}, 32'd1);
    chk("R9 pulled-up data", {16'd0, cmd_rdata[15:0]}, 32'hFFFF);

    // R2 accepted write clears fail
    write_cmd(32'h0000_0000);
    chk("R2 fail cleared", cmd_rdata, 32'h0);

    // R6 opcode 11 drives whole frame
    write_cmd(mk(1, 2'b11, 5'h05, 5'h06, 16'h00FF));
    wait_idle();
    chk("R6 opcode 11 result", cmd_rdata, mk(0, 2'b11, 5'h05, 5'h06, 16'h00FF));

    // R3 write in the completion cycle
    phy_present = 1; phy_data = 16'h8001;
    write_cmd(mk(1, 2'b10, 5'h01, 5'h01, 16'h0000));
    while (m_k != TXN - 1) @(negedge clk);
    cmd_we = 1'b1; cmd_wdata = 32'h0000_1111;
    @(negedge clk);
    cmd_we = 1'b0;
    chk("R3 write at completion ignored", cmd_rdata, mk(0, 2'b10, 5'h01, 5'h01, 16'h8001));
    write_cmd(32'h0000_1111);
    chk("R2 next write accepted", cmd_rdata, 32'h0000_1111);

    repeat (4) @(negedge clk);
    finish_run();
  end
endmodule